// File: doc/BRIEF.md
# Overvoltage Debounce Controller

This block decides whether a battery pack is in the overvoltage condition. It is one piece of a cell-monitor chip. Analog comparators upstream produce, for every cell, one flag that says the cell sits at or above the detect level and another flag that says it sits below the release level. A timer elsewhere raises a one-clock strobe once per monitoring cycle, nominally every 400 ms. Each strobe makes the block evaluate the flags one time. The block changes state only on a clock edge where the strobe is high. At every other edge it holds.

A strobe is a hit when any connected cell reports at or above the detect level. The block counts hits until the count reaches the programmed delay. With a delay of N, the (N+1)th hit declares overvoltage. One clean sample between hits leaves the count unchanged, but two clean samples in a row clear it. After overvoltage is declared, a single strobe on which every connected cell reads below the release level returns the block to normal, with no delay. A mask selects which of the 3 to 5 cell positions are populated, and the block ignores the flags of unpopulated positions.

Top module: `ov_debounce_top`

## Requirements
- R1: A strobe counts as a hit when any cell whose mask bit is 1 has its detect flag set. Bit i of every per-cell vector refers to cell i.
- R2: With a delay setting D (1 to 14), the block enters overvoltage on the hit that arrives while D earlier hits have already been counted. For D = 3, that is the fourth hit.
- R3: One clean strobe (no hit) that follows a counted hit keeps the count, and the next hit continues from that count.
- R4: Two clean strobes in a row clear the count to zero, and `dly_active` drops on the second of them.
- R5: While in overvoltage, a strobe on which every masked-in cell has its release flag set clears `ov_flag` at that same edge.
- R6: While in overvoltage, a strobe on which any masked-in cell lacks its release flag keeps `ov_flag` at 1.
- R7: Flags of cells whose mask bit is 0 do not affect hits or release.
- R8: A delay setting of 0 declares overvoltage on the first hit.
- R9: Delay settings above 14 behave as 14, so 15 hits are needed.
- R10: On edges without a strobe, `ov_flag` and `dly_active` keep their values.
- R11: Synchronous reset clears `ov_flag`, `dly_active` and the count.
- R12: `dly_active` is 1 exactly when the block is in the normal state with a nonzero count. It is 0 while in overvoltage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-clock pulse per monitoring cycle |
| cell_en | input | NCELL (5) | Mask of populated cell positions |
| cell_over | input | NCELL (5) | Per-cell flag: at or above the detect level |
| cell_below_rel | input | NCELL (5) | Per-cell flag: below the release level |
| delay_cfg | input | DLY_W (4) | Programmed delay in monitoring cycles, 0 to 14 |
| ov_flag | output | 1 | Overvoltage state |
| dly_active | output | 1 | A delay count is in progress |

## Verification
A wrong count or a lost gap marker does not show at once. It shows as `ov_flag` rising one strobe too early or too late, and that error appears only at the final hit of a streak, possibly many strobes after the actual fault. `dly_active` exposes whether the count is zero after every strobe. This catches a count that was wrongly cleared or wrongly kept on the very strobe where it happens. A stuck state register shows on the first strobe that should release or declare.

// File: rtl/ovd_pkg.sv
package ovd_pkg;

    typedef enum logic {
        ST_NORMAL = 1'b0,
        ST_OVER   = 1'b1
    } ovd_state_e;

    typedef struct packed {
        logic hit;
        logic released;
    } ovd_eval_t;

    typedef struct packed {
        logic advance;
        logic gap;
        logic clear;
    } ovd_cnt_cmd_t;

    function automatic int unsigned sat_limit(input int unsigned val,
                                              input int unsigned lim);
        return (val > lim) ? lim : val;
    endfunction

endpackage

// File: rtl/ovd_cell_eval.sv
module ovd_cell_eval
    import ovd_pkg::*;
#(
    parameter int NCELL = 5
) (
    input  logic [NCELL-1:0] cell_en,
    input  logic [NCELL-1:0] cell_over,
    input  logic [NCELL-1:0] cell_below_rel,
    output ovd_eval_t        eval
);
    logic [NCELL-1:0] over_m;
    logic [NCELL-1:0] rel_ok;

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        assign over_m[i] = cell_en[i] & cell_over[i];
        assign rel_ok[i] = ~cell_en[i] | cell_below_rel[i];
    end

    always_comb begin
        eval.hit      = |over_m;
        eval.released = &rel_ok;
    end
endmodule

// File: rtl/ovd_streak_counter.sv
module ovd_streak_counter
    import ovd_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  ovd_cnt_cmd_t     cmd,
    output logic [DLY_W-1:0] count
);
    logic gap_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            gap_seen <= 1'b0;
        end else if (cmd.clear) begin
            count    <= '0;
            gap_seen <= 1'b0;
        end else if (cmd.advance) begin
            count    <= count + 1'b1;
            gap_seen <= 1'b0;
        end else if (cmd.gap) begin
            if (gap_seen) begin
                count    <= '0;
                gap_seen <= 1'b0;
            end else begin
                gap_seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ovd_state_ctrl.sv
module ovd_state_ctrl
    import ovd_pkg::*;
#(
    parameter int DLY_W     = 4,
    parameter int MAX_DELAY = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  ovd_eval_t        eval,
    input  logic [DLY_W-1:0] delay_cfg,
    input  logic [DLY_W-1:0] count,
    output ovd_cnt_cmd_t     cmd,
    output ovd_state_e       state
);
    localparam logic [DLY_W-1:0] MAX_D = DLY_W'(MAX_DELAY);

    logic [DLY_W-1:0] eff_delay;
    logic             declare;
    logic             release_now;

    always_comb begin
        eff_delay   = (delay_cfg > MAX_D) ? MAX_D : delay_cfg;
        declare     = stb && (state == ST_NORMAL) && eval.hit && (count >= eff_delay);
        release_now = stb && (state == ST_OVER) && eval.released;
        cmd.clear   = declare || (stb && (state == ST_OVER));
        cmd.advance = stb && (state == ST_NORMAL) && eval.hit && !declare;
        cmd.gap     = stb && (state == ST_NORMAL) && !eval.hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_NORMAL;
        end else if (declare) begin
            state <= ST_OVER;
        end else if (release_now) begin
            state <= ST_NORMAL;
        end
    end
endmodule

// File: rtl/ov_debounce_top.sv
module ov_debounce_top
    import ovd_pkg::*;
#(
    parameter int NCELL     = 5,
    parameter int MAX_DELAY = 14,
    parameter int DLY_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_stb,
    input  logic [NCELL-1:0] cell_en,
    input  logic [NCELL-1:0] cell_over,
    input  logic [NCELL-1:0] cell_below_rel,
    input  logic [DLY_W-1:0] delay_cfg,
    output logic             ov_flag,
    output logic             dly_active
);
    ovd_eval_t        eval;
    ovd_cnt_cmd_t     cmd;
    ovd_state_e       state;
    logic [DLY_W-1:0] count;

    ovd_cell_eval #(.NCELL(NCELL)) u_eval (
        .cell_en        (cell_en),
        .cell_over      (cell_over),
        .cell_below_rel (cell_below_rel),
        .eval           (eval)
    );

    ovd_state_ctrl #(.DLY_W(DLY_W), .MAX_DELAY(MAX_DELAY)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .stb       (sample_stb),
        .eval      (eval),
        .delay_cfg (delay_cfg),
        .count     (count),
        .cmd       (cmd),
        .state     (state)
    );

    ovd_streak_counter #(.DLY_W(DLY_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .count (count)
    );

    assign ov_flag    = (state == ST_OVER);
    assign dly_active = (state == ST_NORMAL) && (count != '0);
endmodule

// File: rtl/ovd_checker.sv
module ovd_checker #(
    parameter int NCELL = 5,
    parameter int DLY_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_stb,
    input logic [NCELL-1:0] cell_en,
    input logic [NCELL-1:0] cell_over,
    input logic [NCELL-1:0] cell_below_rel,
    input logic [DLY_W-1:0] delay_cfg,
    input logic             ov_flag,
    input logic             dly_active
);
    logic chk_hit;
    logic chk_rel;
    assign chk_hit = |(cell_over & cell_en);
    assign chk_rel = &(cell_below_rel | ~cell_en);

    AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ov_flag) |-> $past(sample_stb && chk_hit)); // R1
    AST_ZERO_DELAY_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (!ov_flag && sample_stb && chk_hit && delay_cfg == '0) |=> ov_flag); // R8
    AST_RELEASE_ONE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && sample_stb && chk_rel) |=> !ov_flag); // R5
    AST_HOLD_UNRELEASED: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && sample_stb && !chk_rel) |=> ov_flag); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> ($stable(ov_flag) && $stable(dly_active))); // R10
    AST_NO_COUNT_IN_OVER: assert property (@(posedge clk) disable iff (rst)
        ov_flag |-> !dly_active); // R12
endmodule

bind ov_debounce_top ovd_checker #(.NCELL(NCELL), .DLY_W(DLY_W)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .sample_stb     (sample_stb),
    .cell_en        (cell_en),
    .cell_over      (cell_over),
    .cell_below_rel (cell_below_rel),
    .delay_cfg      (delay_cfg),
    .ov_flag        (ov_flag),
    .dly_active     (dly_active)
);

// File: tb/ov_debounce_top_tb_top.sv
module ov_debounce_top_tb_top;
    localparam int NCELL = 5;
    localparam int DLY_W = 4;
    localparam int NVEC  = 18;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sample_stb = 1'b0;
    logic [NCELL-1:0] cell_en = '1;
    logic [NCELL-1:0] cell_over = '0;
    logic [NCELL-1:0] cell_below_rel = '0;
    logic [DLY_W-1:0] delay_cfg = 4'd3;
    logic             ov_flag;
    logic             dly_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ov_debounce_top #(.NCELL(NCELL)) dut_i (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .cell_en(cell_en),
        .cell_over(cell_over), .cell_below_rel(cell_below_rel),
        .delay_cfg(delay_cfg), .ov_flag(ov_flag), .dly_active(dly_active)
    );

    // {en, over, below, delay, exp_ov, exp_active}
    localparam logic [20:0] VEC [0:NVEC-1] = '{
        {5'h1F, 5'h01, 5'h00, 4'd3, 1'b0, 1'b1},  //  0 R1 first hit
        {5'h1F, 5'h00, 5'h00, 4'd3, 1'b0, 1'b1},  //  1 R3 single gap keeps
        {5'h1F, 5'h04, 5'h00, 4'd3, 1'b0, 1'b1},  //  2 R3 continue
        {5'h1F, 5'h10, 5'h00, 4'd3, 1'b0, 1'b1},  //  3 R2
        {5'h1F, 5'h02, 5'h00, 4'd3, 1'b1, 1'b0},  //  4 R2 fourth hit
        {5'h1F, 5'h00, 5'h0F, 4'd3, 1'b1, 1'b0},  //  5 R6 cell 4 unreleased
        {5'h1F, 5'h00, 5'h1F, 4'd3, 1'b0, 1'b0},  //  6 R5 release
        {5'h1F, 5'h08, 5'h00, 4'd3, 1'b0, 1'b1},  //  7 R12
        {5'h1F, 5'h00, 5'h00, 4'd3, 1'b0, 1'b1},  //  8 R3
        {5'h1F, 5'h00, 5'h00, 4'd3, 1'b0, 1'b0},  //  9 R4 second gap clears
        {5'h1F, 5'h01, 5'h00, 4'd3, 1'b0, 1'b1},  // 10 R4 restart
        {5'h1F, 5'h01, 5'h00, 4'd3, 1'b0, 1'b1},  // 11 R2
        {5'h1F, 5'h01, 5'h00, 4'd3, 1'b0, 1'b1},  // 12 R2
        {5'h1F, 5'h01, 5'h00, 4'd3, 1'b1, 1'b0},  // 13 R2
        {5'h1F, 5'h00, 5'h1F, 4'd3, 1'b0, 1'b0},  // 14 R5
        {5'h1F, 5'h10, 5'h00, 4'd0, 1'b1, 1'b0},  // 15 R8
        {5'h07, 5'h18, 5'h07, 4'd0, 1'b0, 1'b0},  // 16 R7 masked cells ignored in release
        {5'h07, 5'h18, 5'h00, 4'd0, 1'b0, 1'b0}   // 17 R7 masked cells ignored in hit
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:                  return "R1";
            1, 2, 8:            return "R3";
            3, 4, 11, 12, 13:   return "R2";
            5:                  return "R6";
            6, 14:              return "R5";
            7:                  return "R12";
            9, 10:              return "R4";
            15:                 return "R8";
            default:            return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic ov_exp, input logic act_exp);
        n_cmp++;
        if (ov_flag !== ov_exp || dly_active !== act_exp) begin
            n_bad++;
            $display("FAIL %s: ov_flag=%b dly_active=%b expected ov_flag=%b dly_active=%b",
                     tag, ov_flag, dly_active, ov_exp, act_exp);
        end
    endtask

    task automatic strobe(input logic [NCELL-1:0] en, input logic [NCELL-1:0] ov,
                          input logic [NCELL-1:0] bl, input logic [DLY_W-1:0] d);
        @(negedge clk);
        cell_en = en; cell_over = ov; cell_below_rel = bl; delay_cfg = d;
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R11", 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][20:16], VEC[i][15:11], VEC[i][10:6], VEC[i][5:2]);
            check(vec_tag(i), VEC[i][1], VEC[i][0]);
        end

        // R9: setting 15 acts as 14 -> 15 hits needed
        do_reset();
        for (int k = 0; k < 14; k++) strobe(5'h1F, 5'h01, 5'h00, 4'd15);
        check("R9", 1'b0, 1'b1);
        strobe(5'h1F, 5'h01, 5'h00, 4'd15);
        check("R9", 1'b1, 1'b0);

        // R2: setting 14 exact boundary
        do_reset();
        for (int k = 0; k < 14; k++) strobe(5'h1F, 5'h02, 5'h00, 4'd14);
        check("R2", 1'b0, 1'b1);
        strobe(5'h1F, 5'h02, 5'h00, 4'd14);
        check("R2", 1'b1, 1'b0);

        // R10: no strobe, inputs that would release are ignored
        @(negedge clk);
        cell_over = '0; cell_below_rel = '1;
        repeat (5) @(negedge clk);
        check("R10", 1'b1, 1'b0);

        // R11: reset from overvoltage and mid-count
        do_reset();
        check("R11", 1'b0, 1'b0);
        strobe(5'h1F, 5'h01, 5'h00, 4'd3);
        strobe(5'h1F, 5'h01, 5'h00, 4'd3);
        check("R12", 1'b0, 1'b1);
        do_reset();
        check("R11", 1'b0, 1'b0);
        // count truly cleared: needs 4 fresh hits
        for (int k = 0; k < 3; k++) strobe(5'h1F, 5'h01, 5'h00, 4'd3);
        check("R11", 1'b0, 1'b1);
        strobe(5'h1F, 5'h01, 5'h00, 4'd3);
        check("R11", 1'b1, 1'b0);

        // R7: empty-looking over vector on masked cell with 3 cells, delay 0
        do_reset();
        strobe(5'h07, 5'h10, 5'h00, 4'd0);
        check("R7", 1'b0, 1'b0);
        strobe(5'h07, 5'h04, 5'h00, 4'd0);
        check("R1", 1'b1, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule